// File: doc/BRIEF.md
# Flash Bus Write-Cycle Qualifier

This block sits behind the control pins of an asynchronous parallel flash bus and decides, with a fast internal clock, whether a real write cycle has taken place. It watches three active-low controls: chip enable, write enable and output enable. Each pin passes through a two-stage synchronizer. A glitch filter then accepts a new level only after it has held for a set number of consecutive clock samples. The address and data buses go through a matching delay line, so the bus values stay aligned with the filtered control levels.

A write cycle opens when chip enable and write enable are both low while output enable is high. The address is taken at the moment this combination forms, which is the later of the two falling enable edges. Data is taken when the first of the two enables goes high again. At that point the block sends one clock-wide strobe to the downstream command decoder, carrying the latched address and data.

Writes are dropped in three cases. The first is an illegal pin combination: output enable goes low inside the window. The second is while a digital low-supply flag is raised; during that time a reset-to-read request is also held towards the command logic. The third is when the enables were already low at reset. In that case nothing is accepted until chip enable or write enable has been seen high.

Top module: `fbus_write_qualifier`

## Requirements
- R1: A write cycle forms while filtered chip enable = 0, write enable = 0 and output enable = 1. When chip enable or write enable then returns high, `wr_strobe_o` pulses with `wr_addr_o` and `wr_data_o` valid. This holds whichever of the two enables is toggled.
- R2: If output enable goes low while the write combination is active, the cycle is abandoned and no strobe is produced.
- R3: A control pin level is believed only after FILT_LEN consecutive samples (default 3). A pulse lasting 2 samples has no effect: it neither opens a cycle nor closes an open one.
- R4: The latched address is the address bus value at the later of the two enable falling edges.
- R5: The latched data is the data bus value at the earlier of the two enable rising edges. Later changes to the data bus are not taken.
- R6: While `low_supply_i` = 1, no strobe is produced, any open cycle is dropped, and `reset_to_read_o` = 1. `reset_to_read_o` returns to 0 after the flag clears.
- R7: If chip enable and write enable are low with output enable high when reset is released, the first write-enable rising edge produces no strobe. Normal writes are accepted once chip enable or write enable has been seen high.
- R8: Each accepted write yields exactly one strobe, lasting one clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n_i | input | 1 | Chip enable pin, active low, asynchronous |
| we_n_i | input | 1 | Write enable pin, active low, asynchronous |
| oe_n_i | input | 1 | Output enable pin, active low, asynchronous |
| addr_i | input | ADDR_W (20) | Address bus |
| data_i | input | DATA_W (16) | Data bus |
| low_supply_i | input | 1 | Supply below lockout threshold |
| wr_strobe_o | output | 1 | One-cycle qualified write pulse |
| wr_addr_o | output | ADDR_W (20) | Address latched for the write |
| wr_data_o | output | DATA_W (16) | Data latched for the write |
| reset_to_read_o | output | 1 | Request to command logic to return to read mode |

## Verification
The hardest situations to reach are the two edge-ordering cases. In one, the address has to come from the second falling enable while the data comes from the first rising enable. The stimulus handles this by changing the address bus between the two falling edges and the data bus between the two rising edges, so a wrong choice of edge gives a visibly different value. The power-up inhibit is reached by holding both enables low across reset release, then raising write enable before chip enable is ever high.

// File: rtl/fbq_pkg.sv
package fbq_pkg;
  typedef enum logic [0:0] {
    CYC_IDLE  = 1'b0,
    CYC_ARMED = 1'b1
  } cyc_state_e;
endpackage

// File: rtl/fbq_pin_filter.sv
module fbq_pin_filter #(
  parameter int   FILT_LEN = 3,
  parameter logic RST_LVL  = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic level_o
);
  localparam int CNT_W = (FILT_LEN < 2) ? 1 : $clog2(FILT_LEN + 1);

  logic             s1_q, s2_q;
  logic             lvl_q, lvl_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= RST_LVL;
      s2_q <= RST_LVL;
    end else begin
      s1_q <= pin_i;
      s2_q <= s1_q;
    end
  end

  always_comb begin
    lvl_d = lvl_q;
    cnt_d = cnt_q;
    if (s2_q == lvl_q) begin
      cnt_d = '0;
    end else if (cnt_q == CNT_W'(FILT_LEN - 1)) begin
      lvl_d = s2_q;
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= RST_LVL;
      cnt_q <= '0;
    end else begin
      lvl_q <= lvl_d;
      cnt_q <= cnt_d;
    end
  end

  assign level_o = lvl_q;

  AST_FILT_NEW_LEVEL_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_q != $past(lvl_q)) |-> ($past(s2_q) == lvl_q)); // R3
endmodule

// File: rtl/fbq_bus_delay.sv
module fbq_bus_delay #(
  parameter int W     = 16,
  parameter int DEPTH = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] d_o
);
  logic [W-1:0] stage_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    if (g == 0) begin : g_head
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= '0;
        else        stage_q[g] <= d_i;
      end
    end else begin : g_tail
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= '0;
        else        stage_q[g] <= stage_q[g-1];
      end
    end
  end

  assign d_o = stage_q[DEPTH-1];
endmodule

// File: rtl/fbq_cycle_ctrl.sv
module fbq_cycle_ctrl
  import fbq_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_lvl_i,
  input  logic              we_lvl_i,
  input  logic              oe_lvl_i,
  input  logic              lockout_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              strobe_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o
);
  cyc_state_e        state_q, state_d;
  logic              act_q;
  logic              pu_inh_q, pu_inh_d;
  logic              stb_q, stb_d;
  logic              addr_en, data_en;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic              act_now, opening, closing;

  assign act_now = !ce_lvl_i && !we_lvl_i && oe_lvl_i;
  assign opening = act_now && !act_q;
  assign closing = !act_now && act_q;

  always_comb begin
    state_d  = state_q;
    stb_d    = 1'b0;
    addr_en  = 1'b0;
    data_en  = 1'b0;
    pu_inh_d = pu_inh_q && !(ce_lvl_i || we_lvl_i);
    if (lockout_i) begin
      state_d = CYC_IDLE;
    end else if (opening) begin
      if (!pu_inh_q) begin
        state_d = CYC_ARMED;
        addr_en = 1'b1;
      end
    end else if (closing && state_q == CYC_ARMED) begin
      state_d = CYC_IDLE;
      if (oe_lvl_i) begin
        stb_d   = 1'b1;
        data_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= CYC_IDLE;
      act_q    <= 1'b1;
      pu_inh_q <= 1'b1;
      stb_q    <= 1'b0;
    end else begin
      state_q  <= state_d;
      act_q    <= act_now;
      pu_inh_q <= pu_inh_d;
      stb_q    <= stb_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (addr_en) begin
      addr_q <= addr_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (data_en) begin
      data_q <= data_i;
    end
  end

  assign strobe_o = stb_q;
  assign addr_o   = addr_q;
  assign data_o   = data_q;

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    stb_q |=> !stb_q); // R8
  AST_STROBE_NEEDS_OE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    stb_q |-> $past(oe_lvl_i)); // R2
  AST_NO_STROBE_LOCKOUT: assert property (@(posedge clk) disable iff (!rst_n)
    lockout_i |=> !stb_q); // R6
  AST_NO_STROBE_POWERUP: assert property (@(posedge clk) disable iff (!rst_n)
    pu_inh_q |=> !stb_q); // R7
  AST_STROBE_AFTER_ENABLE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    stb_q |-> ($past(ce_lvl_i) || $past(we_lvl_i))); // R1
endmodule

// File: rtl/fbus_write_qualifier.sv
module fbus_write_qualifier #(
  parameter int ADDR_W   = 20,
  parameter int DATA_W   = 16,
  parameter int FILT_LEN = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n_i,
  input  logic              we_n_i,
  input  logic              oe_n_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              low_supply_i,
  output logic              wr_strobe_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              reset_to_read_o
);
  localparam int BUS_DLY = FILT_LEN + 2;

  logic              ce_lvl, we_lvl, oe_lvl;
  logic              lv_s1_q, lv_s2_q;
  logic [ADDR_W-1:0] addr_dly;
  logic [DATA_W-1:0] data_dly;

  fbq_pin_filter #(.FILT_LEN(FILT_LEN), .RST_LVL(1'b0)) u_ce_filt (
    .clk(clk), .rst_n(rst_n), .pin_i(ce_n_i), .level_o(ce_lvl));
  fbq_pin_filter #(.FILT_LEN(FILT_LEN), .RST_LVL(1'b0)) u_we_filt (
    .clk(clk), .rst_n(rst_n), .pin_i(we_n_i), .level_o(we_lvl));
  fbq_pin_filter #(.FILT_LEN(FILT_LEN), .RST_LVL(1'b1)) u_oe_filt (
    .clk(clk), .rst_n(rst_n), .pin_i(oe_n_i), .level_o(oe_lvl));

  fbq_bus_delay #(.W(ADDR_W), .DEPTH(BUS_DLY)) u_addr_dly (
    .clk(clk), .rst_n(rst_n), .d_i(addr_i), .d_o(addr_dly));
  fbq_bus_delay #(.W(DATA_W), .DEPTH(BUS_DLY)) u_data_dly (
    .clk(clk), .rst_n(rst_n), .d_i(data_i), .d_o(data_dly));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lv_s1_q <= 1'b0;
      lv_s2_q <= 1'b0;
    end else begin
      lv_s1_q <= low_supply_i;
      lv_s2_q <= lv_s1_q;
    end
  end

  fbq_cycle_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce_lvl_i  (ce_lvl),
    .we_lvl_i  (we_lvl),
    .oe_lvl_i  (oe_lvl),
    .lockout_i (lv_s2_q),
    .addr_i    (addr_dly),
    .data_i    (data_dly),
    .strobe_o  (wr_strobe_o),
    .addr_o    (wr_addr_o),
    .data_o    (wr_data_o)
  );

  assign reset_to_read_o = lv_s2_q;

  AST_RESET_READ_FOLLOWS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reset_to_read_o) |-> $past(lv_s1_q)); // R6
endmodule

// File: tb/fbus_write_qualifier_tb_top.sv
module fbus_write_qualifier_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [19:0] addr = '0;
  logic [15:0] data = '0;
  logic        low_supply = 1'b0;
  logic        wr_strobe, reset_to_read;
  logic [19:0] wr_addr;
  logic [15:0] wr_data;

  int total = 0;
  int bad   = 0;
  int strobe_cnt = 0;
  bit finished = 0;
  logic prev_stb = 1'b0;

  logic [19:0] exp_a[$];
  logic [15:0] exp_d[$];
  string       exp_tag[$];

  always #2 clk = ~clk;

  fbus_write_qualifier dut_i (
    .clk(clk), .rst_n(rst_n), .ce_n_i(ce_n), .we_n_i(we_n), .oe_n_i(oe_n),
    .addr_i(addr), .data_i(data), .low_supply_i(low_supply),
    .wr_strobe_o(wr_strobe), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .reset_to_read_o(reset_to_read));

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push_exp(input logic [19:0] a, input logic [15:0] d, input string tag);
    exp_a.push_back(a);
    exp_d.push_back(d);
    exp_tag.push_back(tag);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (wr_strobe) begin
        strobe_cnt++;
        check(!prev_stb, "R8 strobe longer than one cycle", 1, 0);
        if (exp_a.size() == 0) begin
          check(1'b0, "R1 unexpected strobe", wr_addr, 0);
        end else begin
          logic [19:0] ea;
          logic [15:0] ed;
          string t;
          ea = exp_a.pop_front();
          ed = exp_d.pop_front();
          t  = exp_tag.pop_front();
          check(wr_addr == ea, {t, " address"}, wr_addr, ea);
          check(wr_data == ed, {t, " data"}, wr_data, ed);
        end
      end
      prev_stb <= wr_strobe;
    end
  end

  task automatic we_write(input logic [19:0] a, input logic [15:0] d);
    addr = a; data = d; oe_n = 1'b1;
    ce_n = 1'b0; wait_cyc(10);
    we_n = 1'b0; wait_cyc(12);
    we_n = 1'b1; wait_cyc(10);
    ce_n = 1'b1; wait_cyc(12);
  endtask

  task automatic ce_write(input logic [19:0] a, input logic [15:0] d);
    addr = a; data = d; oe_n = 1'b1;
    we_n = 1'b0; wait_cyc(10);
    ce_n = 1'b0; wait_cyc(12);
    ce_n = 1'b1; wait_cyc(10);
    we_n = 1'b1; wait_cyc(12);
  endtask

  initial begin
    int base;
    wait_cyc(5);
    rst_n = 1'b1;
    wait_cyc(20);
    check(wr_strobe == 1'b0, "R1 reset strobe", wr_strobe, 0);
    check(reset_to_read == 1'b0, "R6 reset request idle", reset_to_read, 0);

    // R1 write-enable controlled
    push_exp(20'h12345, 16'hBEEF, "R1 we-ctrl");
    we_write(20'h12345, 16'hBEEF);
    // R1 chip-enable controlled
    push_exp(20'hFEDCB, 16'h0A55, "R1 ce-ctrl");
    ce_write(20'hFEDCB, 16'h0A55);
    check(strobe_cnt == 2, "R1 strobe count", strobe_cnt, 2);

    // R2 output enable low during window
    base = strobe_cnt;
    addr = 20'h00111; data = 16'h1111;
    ce_n = 1'b0; wait_cyc(10);
    we_n = 1'b0; wait_cyc(12);
    oe_n = 1'b0; wait_cyc(12);
    we_n = 1'b1; wait_cyc(10);
    ce_n = 1'b1; wait_cyc(6);
    oe_n = 1'b1; wait_cyc(12);
    check(strobe_cnt == base, "R2 oe low blocks write", strobe_cnt, base);

    // R3 two-sample write-enable glitch does not open a cycle
    base = strobe_cnt;
    addr = 20'h00222; data = 16'h2222;
    ce_n = 1'b0; wait_cyc(10);
    we_n = 1'b0; wait_cyc(2); we_n = 1'b1; wait_cyc(15);
    ce_n = 1'b1; wait_cyc(12);
    check(strobe_cnt == base, "R3 low glitch ignored", strobe_cnt, base);

    // R3 two-sample high glitch inside a cycle does not close it
    base = strobe_cnt;
    push_exp(20'h00333, 16'h3333, "R3 high glitch");
    addr = 20'h00333; data = 16'h3333;
    ce_n = 1'b0; wait_cyc(10);
    we_n = 1'b0; wait_cyc(12);
    we_n = 1'b1; wait_cyc(2); we_n = 1'b0; wait_cyc(12);
    we_n = 1'b1; wait_cyc(10);
    ce_n = 1'b1; wait_cyc(12);
    check(strobe_cnt == base + 1, "R3 single strobe", strobe_cnt, base + 1);

    // R4 / R5 overlapping enables
    push_exp(20'hA2A2A, 16'hD1D1, "R4/R5 overlap A");
    addr = 20'hA1A1A; data = 16'h0000;
    we_n = 1'b0; wait_cyc(12);
    addr = 20'hA2A2A; wait_cyc(12);   // R4: address after first fall
    ce_n = 1'b0; wait_cyc(12);
    data = 16'hD1D1; wait_cyc(12);
    ce_n = 1'b1; wait_cyc(12);        // R5: first rise
    data = 16'hD2D2; wait_cyc(12);
    we_n = 1'b1; wait_cyc(12);
    push_exp(20'h5C5C5, 16'h7777, "R4/R5 overlap B");
    addr = 20'h11111; data = 16'h0000;
    ce_n = 1'b0; wait_cyc(12);
    addr = 20'h5C5C5; wait_cyc(12);
    we_n = 1'b0; wait_cyc(12);
    addr = 20'h99999; data = 16'h7777; wait_cyc(12);
    we_n = 1'b1; wait_cyc(12);
    data = 16'h8888; wait_cyc(12);
    ce_n = 1'b1; wait_cyc(12);

    // R6 low supply lockout
    base = strobe_cnt;
    low_supply = 1'b1; wait_cyc(5);
    check(reset_to_read == 1'b1, "R6 reset request raised", reset_to_read, 1);
    we_write(20'h06666, 16'h6666);
    check(strobe_cnt == base, "R6 write ignored", strobe_cnt, base);
    // cycle opened before lockout is dropped
    low_supply = 1'b0; wait_cyc(5);
    ce_n = 1'b0; wait_cyc(10);
    we_n = 1'b0; wait_cyc(12);
    low_supply = 1'b1; wait_cyc(8);
    low_supply = 1'b0; wait_cyc(8);
    we_n = 1'b1; wait_cyc(10);
    ce_n = 1'b1; wait_cyc(12);
    check(strobe_cnt == base, "R6 open cycle dropped", strobe_cnt, base);
    check(reset_to_read == 1'b0, "R6 reset request cleared", reset_to_read, 0);

    // R7 pins active through reset
    rst_n = 1'b0;
    ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1; addr = 20'h07777; data = 16'h7777;
    wait_cyc(5);
    rst_n = 1'b1; wait_cyc(20);
    base = strobe_cnt;
    we_n = 1'b1; wait_cyc(12);
    ce_n = 1'b1; wait_cyc(12);
    check(strobe_cnt == base, "R7 power-up write ignored", strobe_cnt, base);
    push_exp(20'h0ABCD, 16'hCAFE, "R7 after release");
    we_write(20'h0ABCD, 16'hCAFE);

    wait_cyc(10);
    check(exp_a.size() == 0, "R1 pending expected strobes", exp_a.size(), 0);
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule